// File: doc/BRIEF.md
# Processor Bus Machine-Cycle Sequencer

This block produces the external bus strobes of an 8-bit processor with a 16-bit address bus. The core asks for one machine cycle at a time. Each request carries a cycle kind, an address and, for writes, a data byte. The sequencer then steps through T-states, one clock each. It drives the active-low read, write, memory-request, I/O-request, first-cycle (M1) and refresh strobes. It also drives the address and write data, each with an output enable. Read data is captured into a holding register that the core picks up when the cycle ends.

Three behaviours are built into the cycle timing. An opcode fetch spends its last two T-states refreshing DRAM: the address bus then carries the refresh counter. I/O cycles get a fixed number of extra wait states, and so do interrupt-acknowledge cycles. A slow device can stretch any cycle further by pulling the wait input low. An external master can ask for the bus. The request is granted only between machine cycles, and while it is granted the block lets go of the address, data and control lines.

Top module: `busCycleSeq`

## Requirements
- R1: While `rstN` is low, every strobe output is high, `addrOe`, `dataOe` and `ctrlOe` are low, `busAckN` is high and `rfshReg` is 0. After reset is released, the idle bus drives address and control (`addrOe`=`ctrlOe`=1) with all strobes high and `reqReady`=1.
- R2: A memory read (`reqKind`=1) with `waitN` high lasts 3 T-states. `mreqN` and `rdN` are low in all three, `busAddr` equals the request address, and `rdData` takes `busDataIn` on the clock edge that ends the last T-state.
- R3: A memory write (`reqKind`=2) lasts 3 T-states with `waitN` high. `mreqN` is low throughout, `wrN` is low from the second T-state to the last, and `dataOe`=1 with `busDataOut` equal to the request data throughout. `rdN` stays high.
- R4: An opcode fetch (`reqKind`=0) lasts 4 T-states plus any wait states. `m1N`, `mreqN` and `rdN` are low in every T-state except the final two. In the final two, `rfshN` and `mreqN` are low, `m1N` and `rdN` are high, and `busAddr` is `{8'h00, rfshReg}`. Read data is captured on the edge that ends the last T-state before the refresh phase.
- R5: At the end of each opcode fetch, bits 6:0 of the refresh register increase by one and wrap from 7F to 00. Bit 7 does not change.
- R6: A one-clock pulse on `rfshLoad` writes `rfshLoadVal` into the refresh register. If the pulse falls in the same clock as a fetch increment, the loaded value wins.
- R7: `waitN` is sampled at the end of the second T-state and of each wait state, once the automatic wait states of the cycle are used up. Each low sample adds one wait T-state. `waitN` has no effect while automatic wait states are still pending, and all strobes hold their levels through wait states.
- R8: I/O read (`reqKind`=3) and I/O write (`reqKind`=4) use `iorqN` in place of `mreqN`, with the same `rdN`/`wrN`/data timing as R2 and R3. Each gets exactly one automatic wait state, so it lasts 4 T-states with `waitN` high.
- R9: An interrupt acknowledge (`reqKind`=5) holds `m1N` and `iorqN` low with `rdN` and `mreqN` high. It gets two automatic wait states, so it lasts 5 T-states with `waitN` high, and it captures `busDataIn` at its end.
- R10: A low `busReqN` is acted on only at the end of a machine cycle or while idle. The clock edge that grants it sets `busAckN` low and drops `addrOe`, `dataOe` and `ctrlOe`. Requests presented during the grant are ignored. When `busReqN` returns high, one edge later `busAckN` goes high and the bus is driven again.
- R11: `reqReady` is high only while idle with `busReqN` high. A request is taken on a clock edge where `reqValid` and `reqReady` are both high. `cycDone` is high for exactly the one clock that follows the last T-state of each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one T-state |
| rstN | input | 1 | Asynchronous reset, active low, held at least three clocks |
| reqValid | input | 1 | Core presents a cycle request |
| reqKind | input | 3 | Cycle kind: 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge |
| reqAddr | input | 16 | Address for the requested cycle |
| reqWrData | input | 8 | Write data for the requested cycle |
| reqReady | output | 1 | Sequencer can take a request this clock |
| cycDone | output | 1 | One-clock pulse after the last T-state |
| rdData | output | 8 | Captured read data |
| busAddr | output | 16 | Address bus value |
| addrOe | output | 1 | Address bus output enable |
| busDataOut | output | 8 | Data bus value driven by the block |
| busDataIn | input | 8 | Data bus value from memory or I/O |
| dataOe | output | 1 | Data bus output enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| mreqN | output | 1 | Memory request, active low |
| iorqN | output | 1 | I/O request, active low |
| m1N | output | 1 | First-cycle strobe, active low |
| rfshN | output | 1 | Refresh strobe, active low |
| ctrlOe | output | 1 | Control strobe output enable |
| waitN | input | 1 | Wait request from slow devices, active low |
| busReqN | input | 1 | External bus request, active low |
| busAckN | output | 1 | Bus grant, active low |
| rfshLoad | input | 1 | Load refresh register |
| rfshLoadVal | input | 8 | Value for refresh load |
| rfshReg | output | 8 | Current refresh register |

## Verification
The assertions assume that `reqKind` holds one of the six defined codes whenever a request is taken, and that `waitN` and `busReqN` change only away from the active clock edge. They also assume `rfshLoad` is a single-clock pulse. The stimulus keeps to these limits: it drives only codes 0 to 5 and sets every input at the falling edge. It pulses the refresh load for one clock, either while idle or in the final refresh T-state of a fetch. Wait stretches are placed both after and inside the automatic wait window, and bus requests are raised both while idle and in the middle of a cycle.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_MRD   = 3'd1,
    CYC_MWR   = 3'd2,
    CYC_IORD  = 3'd3,
    CYC_IOWR  = 3'd4,
    CYC_INTA  = 3'd5
  } cycKindT;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } tStateT;

  // registered pin-level strobes, active high inside the block
  typedef struct packed {
    logic rd;
    logic wr;
    logic mreq;
    logic iorq;
    logic m1;
    logic rfsh;
    logic drvAddr;
    logic drvData;
    logic drvCtrl;
  } strobeT;

  // control to datapath
  typedef struct packed {
    logic accept;
    logic capture;
    logic rfshInc;
    logic useRfsh;
  } pathCtlT;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
#(
  parameter int IO_WAITS   = 1,
  parameter int INTA_WAITS = 2,
  parameter int WCNT_W     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  input  logic       waitN,
  input  logic       busReqN,
  output logic       reqReady,
  output logic       cycDone,
  output logic       busAck,
  output strobeT     pins,
  output pathCtlT    pathCtl
);

  tStateT              state, nState;
  cycKindT             kind, nKind;
  logic [WCNT_W-1:0]   autoLeft, nAuto;
  strobeT              pinsQ;
  logic                useRfshQ;
  logic                ackQ;
  logic                doneQ;
  tStateT              endSt;
  logic                lastSt;
  logic                isFetch;
  logic                isWrite;

  function automatic logic [WCNT_W-1:0] autoFor(input cycKindT k);
    case (k)
      CYC_IORD, CYC_IOWR: autoFor = WCNT_W'(IO_WAITS);
      CYC_INTA:           autoFor = WCNT_W'(INTA_WAITS);
      default:            autoFor = '0;
    endcase
  endfunction

  function automatic strobeT pinsFor(input tStateT s, input cycKindT k);
    strobeT p;
    logic   wrKind;
    p      = '0;
    wrKind = (k == CYC_MWR) || (k == CYC_IOWR);
    case (s)
      ST_IDLE: begin
        p.drvAddr = 1'b1;
        p.drvCtrl = 1'b1;
      end
      ST_T1, ST_T2, ST_TW, ST_T3, ST_T4: begin
        p.drvAddr = 1'b1;
        p.drvCtrl = 1'b1;
        p.drvData = wrKind && (s != ST_T4);
        if (k == CYC_FETCH) begin
          if (s == ST_T3 || s == ST_T4) begin
            p.mreq = 1'b1;
            p.rfsh = 1'b1;
          end else begin
            p.mreq = 1'b1;
            p.m1   = 1'b1;
            p.rd   = 1'b1;
          end
        end else begin
          p.mreq = (k == CYC_MRD) || (k == CYC_MWR);
          p.iorq = (k == CYC_IORD) || (k == CYC_IOWR) || (k == CYC_INTA);
          p.m1   = (k == CYC_INTA);
          p.rd   = (k == CYC_MRD) || (k == CYC_IORD);
          p.wr   = wrKind && (s != ST_T1);
        end
      end
      default: p = '0;
    endcase
    pinsFor = p;
  endfunction

  assign isFetch = (kind == CYC_FETCH);
  assign isWrite = (kind == CYC_MWR) || (kind == CYC_IOWR);
  assign endSt   = busReqN ? ST_IDLE : ST_HOLD;
  assign lastSt  = (state == ST_T4) || ((state == ST_T3) && !isFetch);

  always_comb begin
    nState = state;
    nKind  = kind;
    nAuto  = autoLeft;
    case (state)
      ST_IDLE: begin
        if (!busReqN) begin
          nState = ST_HOLD;
        end else if (reqValid) begin
          nState = ST_T1;
          nKind  = cycKindT'(reqKind);
          nAuto  = autoFor(cycKindT'(reqKind));
        end
      end
      ST_T1: nState = ST_T2;
      ST_T2, ST_TW: begin
        if (autoLeft != '0) begin
          nState = ST_TW;
          nAuto  = autoLeft - WCNT_W'(1);
        end else if (!waitN) begin
          nState = ST_TW;
        end else begin
          nState = ST_T3;
        end
      end
      ST_T3:   nState = isFetch ? ST_T4 : endSt;
      ST_T4:   nState = endSt;
      ST_HOLD: nState = busReqN ? ST_IDLE : ST_HOLD;
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kind     <= CYC_FETCH;
      autoLeft <= '0;
      pinsQ    <= '0;
      useRfshQ <= 1'b0;
      ackQ     <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      state    <= nState;
      kind     <= nKind;
      autoLeft <= nAuto;
      pinsQ    <= pinsFor(nState, nKind);
      useRfshQ <= (nKind == CYC_FETCH) && (nState == ST_T3 || nState == ST_T4);
      ackQ     <= (nState == ST_HOLD);
      doneQ    <= lastSt;
    end
  end

  assign reqReady        = (state == ST_IDLE) && busReqN;
  assign cycDone         = doneQ;
  assign busAck          = ackQ;
  assign pins            = pinsQ;
  assign pathCtl.accept  = (state == ST_IDLE) && busReqN && reqValid;
  assign pathCtl.capture = (isFetch && (state == ST_T2 || state == ST_TW) && nState == ST_T3)
                         || (!isFetch && !isWrite && state == ST_T3);
  assign pathCtl.rfshInc = (state == ST_T4);
  assign pathCtl.useRfsh = useRfshQ;

  AST_IO_AUTO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T2 && (kind == CYC_IORD || kind == CYC_IOWR) && IO_WAITS >= 1)
      |=> (state == ST_TW)); // R8

  AST_INTA_TWO_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T2 && kind == CYC_INTA && INTA_WAITS >= 2)
      |=> (state == ST_TW) ##1 (state == ST_TW)); // R9

  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_T2 || state == ST_TW) && autoLeft == '0 && !waitN)
      |=> (state == ST_TW) && $stable(pinsQ)); // R7

  AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |-> !pinsQ.drvAddr && !pinsQ.drvData && !pinsQ.drvCtrl); // R10

  AST_NO_MIDCYCLE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T1 || state == ST_T2 || state == ST_TW) |=> !ackQ); // R10

  AST_RFSH_WITH_MREQ: assert property (@(posedge clk) disable iff (!rstN)
    pinsQ.rfsh |-> pinsQ.mreq && !pinsQ.rd && !pinsQ.m1 && useRfshQ); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ); // R11

endmodule

// File: rtl/busSeqPath.sv
module busSeqPath
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RFSH_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtlT           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              rfshLoad,
  input  logic [DATA_W-1:0] rfshLoadVal,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] rfshReg
);

  localparam int PAD_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdQ;
  logic [DATA_W-1:0] rdQ;
  logic [DATA_W-1:0] rfshQ;
  logic [DATA_W-1:0] rfshStep;

  generate
    if (RFSH_W < DATA_W) begin : g_partialRfsh
      assign rfshStep = {rfshQ[DATA_W-1:RFSH_W], rfshQ[RFSH_W-1:0] + RFSH_W'(1)};

      AST_RFSH_STEP: assert property (@(posedge clk) disable iff (!rstN)
        (ctl.rfshInc && !rfshLoad)
          |=> (rfshQ[DATA_W-1:RFSH_W] == $past(rfshQ[DATA_W-1:RFSH_W]))
           && (rfshQ[RFSH_W-1:0] == $past(rfshQ[RFSH_W-1:0]) + RFSH_W'(1))); // R5
    end else begin : g_fullRfsh
      assign rfshStep = rfshQ + DATA_W'(1);

      AST_RFSH_STEP: assert property (@(posedge clk) disable iff (!rstN)
        (ctl.rfshInc && !rfshLoad) |=> (rfshQ == $past(rfshQ) + DATA_W'(1))); // R5
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      wdQ   <= '0;
      rdQ   <= '0;
      rfshQ <= '0;
    end else begin
      if (ctl.accept) begin
        addrQ <= reqAddr;
        wdQ   <= reqWrData;
      end
      if (ctl.capture) begin
        rdQ <= busDataIn;
      end
      if (rfshLoad) begin
        rfshQ <= rfshLoadVal;
      end else if (ctl.rfshInc) begin
        rfshQ <= rfshStep;
      end
    end
  end

  assign busAddr    = ctl.useRfsh ? {{PAD_W{1'b0}}, rfshQ} : addrQ;
  assign busDataOut = wdQ;
  assign rdData     = rdQ;
  assign rfshReg    = rfshQ;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    rfshLoad |=> (rfshQ == $past(rfshLoadVal))); // R6

  AST_CAPTURE_TAKES_BUS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (rdQ == $past(busDataIn))); // R2

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.accept |=> $stable(addrQ)); // R2

endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RFSH_W     = 7,
  parameter int IO_WAITS   = 1,
  parameter int INTA_WAITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              reqReady,
  output logic              cycDone,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              addrOe,
  output logic [DATA_W-1:0] busDataOut,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              dataOe,
  output logic              rdN,
  output logic              wrN,
  output logic              mreqN,
  output logic              iorqN,
  output logic              m1N,
  output logic              rfshN,
  output logic              ctrlOe,
  input  logic              waitN,
  input  logic              busReqN,
  output logic              busAckN,
  input  logic              rfshLoad,
  input  logic [DATA_W-1:0] rfshLoadVal,
  output logic [DATA_W-1:0] rfshReg
);

  localparam int MAX_WAITS = (IO_WAITS > INTA_WAITS) ? IO_WAITS : INTA_WAITS;
  localparam int WCNT_W    = (MAX_WAITS < 1) ? 1 : $clog2(MAX_WAITS + 1);

  strobeT  pins;
  pathCtlT pathCtl;
  logic    busAck;

  busSeqCtrl #(
    .IO_WAITS  (IO_WAITS),
    .INTA_WAITS(INTA_WAITS),
    .WCNT_W    (WCNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqKind (reqKind),
    .waitN   (waitN),
    .busReqN (busReqN),
    .reqReady(reqReady),
    .cycDone (cycDone),
    .busAck  (busAck),
    .pins    (pins),
    .pathCtl (pathCtl)
  );

  busSeqPath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .RFSH_W(RFSH_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (pathCtl),
    .reqAddr    (reqAddr),
    .reqWrData  (reqWrData),
    .busDataIn  (busDataIn),
    .rfshLoad   (rfshLoad),
    .rfshLoadVal(rfshLoadVal),
    .busAddr    (busAddr),
    .busDataOut (busDataOut),
    .rdData     (rdData),
    .rfshReg    (rfshReg)
  );

  assign rdN     = ~pins.rd;
  assign wrN     = ~pins.wr;
  assign mreqN   = ~pins.mreq;
  assign iorqN   = ~pins.iorq;
  assign m1N     = ~pins.m1;
  assign rfshN   = ~pins.rfsh;
  assign addrOe  = pins.drvAddr;
  assign dataOe  = pins.drvData;
  assign ctrlOe  = pins.drvCtrl;
  assign busAckN = ~busAck;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN) && !(!mreqN && !iorqN)); // R3

endmodule

// File: tb/sim_busCycleSeq.sv
module sim_busCycleSeq;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = 3'd0;
  logic [15:0] reqAddr = 16'h0;
  logic [7:0]  reqWrData = 8'h0;
  logic        reqReady, cycDone;
  logic [7:0]  rdData;
  logic [15:0] busAddr;
  logic        addrOe;
  logic [7:0]  busDataOut;
  logic [7:0]  busDataIn = 8'h0;
  logic        dataOe, rdN, wrN, mreqN, iorqN, m1N, rfshN, ctrlOe;
  logic        waitN = 1'b1;
  logic        busReqN = 1'b1;
  logic        busAckN;
  logic        rfshLoad = 1'b0;
  logic [7:0]  rfshLoadVal = 8'h0;
  logic [7:0]  rfshReg;

  int tests = 0;
  int fails = 0;
  logic [7:0] expR = 8'h00;

  always #(CLK_P/2) clk = ~clk;

  busCycleSeq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .reqReady(reqReady),
    .cycDone(cycDone), .rdData(rdData), .busAddr(busAddr), .addrOe(addrOe),
    .busDataOut(busDataOut), .busDataIn(busDataIn), .dataOe(dataOe),
    .rdN(rdN), .wrN(wrN), .mreqN(mreqN), .iorqN(iorqN), .m1N(m1N),
    .rfshN(rfshN), .ctrlOe(ctrlOe), .waitN(waitN), .busReqN(busReqN),
    .busAckN(busAckN), .rfshLoad(rfshLoad), .rfshLoadVal(rfshLoadVal),
    .rfshReg(rfshReg)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string kindTag(input int k);
    case (k)
      0: kindTag = "R4";
      1: kindTag = "R2";
      2: kindTag = "R3";
      3, 4: kindTag = "R8";
      default: kindTag = "R9";
    endcase
  endfunction

  // strobe vector: rdN wrN mreqN iorqN m1N rfshN dataOe busAckN ctrlOe addrOe
  function automatic logic [9:0] expVec(input int k, input int i, input int len);
    bit refr, isWr;
    refr = (k == 0) && (i > len - 2);
    isWr = (k == 2) || (k == 4);
    expVec = { !(((k == 0) && !refr) || k == 1 || k == 3),
               !(isWr && i >= 2),
               !(k == 0 || k == 1 || k == 2),
               !(k == 3 || k == 4 || k == 5),
               !(((k == 0) && !refr) || k == 5),
               !refr,
               isWr,
               1'b1, 1'b1, 1'b1 };
  endfunction

  task automatic doCycle(input int k, input int waitStart, input int waitLen,
                         input int expExtra, input bit loadAtEnd,
                         input logic [7:0] loadVal, input bit busMid);
    int autoW, len, i, guard, badIdx;
    logic [7:0] dval, badAct, badExp;
    logic [15:0] addr, badAddrAct, badAddrExp;
    logic [9:0] av, ev;
    bit patOk, addrOk;
    autoW = (k == 3 || k == 4) ? 1 : (k == 5) ? 2 : 0;
    len   = ((k == 0) ? 4 : 3) + autoW + expExtra;
    if (waitStart < 0) waitStart = 2 + autoW;
    addr  = 16'h1000 + 16'(k * 16'h0111) + 16'(waitLen);
    dval  = 8'h5A ^ 8'(k * 8'h13 + waitLen);
    patOk = 1'b1; addrOk = 1'b1; badIdx = 0;
    badAct = '0; badExp = '0; badAddrAct = '0; badAddrExp = '0;
    guard = 0;
    while (!reqReady && guard < 50) begin @(negedge clk); guard++; end
    reqValid = 1'b1; reqKind = 3'(k); reqAddr = addr;
    reqWrData = ~dval; busDataIn = dval;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    i = 0;
    while (!cycDone && i < 40) begin
      i++;
      av = {rdN, wrN, mreqN, iorqN, m1N, rfshN, dataOe, busAckN, ctrlOe, addrOe};
      ev = expVec(k, i, len);
      if (av !== ev && patOk) begin
        patOk = 1'b0; badIdx = i; badAct = av[9:2]; badExp = ev[9:2];
      end
      if ((k == 0) && (i > len - 2)) begin
        if (busAddr !== {8'h00, expR} && addrOk) begin
          addrOk = 1'b0; badAddrAct = busAddr; badAddrExp = {8'h00, expR};
        end
      end else if (busAddr !== addr && addrOk) begin
        addrOk = 1'b0; badAddrAct = busAddr; badAddrExp = addr;
      end
      if ((k == 2 || k == 4) && busDataOut !== ~dval && patOk) begin
        patOk = 1'b0; badIdx = i; badAct = busDataOut; badExp = ~dval;
      end
      waitN = !(i >= waitStart && i < waitStart + waitLen);
      if (k == 0 && i == len - 1) busDataIn = ~dval;
      if (loadAtEnd && i == len) begin rfshLoad = 1'b1; rfshLoadVal = loadVal; end
      if (busMid && i == 1) busReqN = 1'b0;
      @(negedge clk);
    end
    waitN = 1'b1;
    rfshLoad = 1'b0;
    chk(i == len, (expExtra > 0) ? "R7" : kindTag(k), "cycle length", i, len);
    chk(patOk, kindTag(k), $sformatf("strobes at T-state %0d", badIdx), badAct, badExp);
    chk(addrOk, kindTag(k), "address bus", badAddrAct, badAddrExp);
    if (k == 0 || k == 1 || k == 3 || k == 5)
      chk(rdData === dval, kindTag(k), "captured read data", rdData, dval);
    if (k == 0) expR = loadAtEnd ? loadVal : {expR[7], expR[6:0] + 7'd1};
    chk(rfshReg === expR, loadAtEnd ? "R6" : "R5", "refresh register", rfshReg, expR);
    @(negedge clk);
    chk(cycDone === 1'b0, "R11", "done pulse width", cycDone, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk({rdN, wrN, mreqN, iorqN, m1N, rfshN} === 6'h3F, "R1", "strobes in reset",
        {rdN, wrN, mreqN, iorqN, m1N, rfshN}, 6'h3F);
    chk({addrOe, dataOe, ctrlOe} === 3'b000, "R1", "enables in reset",
        {addrOe, dataOe, ctrlOe}, 0);
    chk(busAckN === 1'b1 && rfshReg === 8'h00, "R1", "ack and refresh in reset",
        {busAckN, rfshReg}, 9'h100);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk({addrOe, ctrlOe, dataOe, reqReady, mreqN, rdN} === 6'b110111, "R1",
        "idle after reset", {addrOe, ctrlOe, dataOe, reqReady, mreqN, rdN}, 6'b110111);

    // sweep: every kind with 0..2 extra WAIT samples
    for (int k = 0; k < 6; k++) begin
      for (int w = 0; w < 3; w++) begin
        doCycle(k, -1, w, w, 1'b0, 8'h00, 1'b0);
      end
    end

    // R7: WAIT low only inside the automatic window is ignored (R8 cycle)
    doCycle(3, 2, 1, 0, 1'b0, 8'h00, 1'b0);
    // R9: WAIT low across both automatic states of an acknowledge is ignored
    doCycle(5, 2, 2, 0, 1'b0, 8'h00, 1'b0);

    // R6: load while idle, then R5 wrap keeps bit 7
    @(negedge clk);
    rfshLoad = 1'b1; rfshLoadVal = 8'hFF;
    @(negedge clk);
    rfshLoad = 1'b0;
    expR = 8'hFF;
    chk(rfshReg === 8'hFF, "R6", "idle load", rfshReg, 8'hFF);
    doCycle(0, -1, 0, 0, 1'b0, 8'h00, 1'b0);
    chk(rfshReg === 8'h80, "R5", "wrap keeps bit 7", rfshReg, 8'h80);
    // R6: load in the same clock as the increment wins
    doCycle(0, -1, 0, 0, 1'b1, 8'h33, 1'b0);

    // R10: bus request raised mid-cycle is granted only after the cycle
    doCycle(1, -1, 0, 0, 1'b0, 8'h00, 1'b1);
    chk(busAckN === 1'b0, "R10", "grant after cycle", busAckN, 0);
    chk({addrOe, dataOe, ctrlOe, reqReady} === 4'b0000, "R10", "bus released",
        {addrOe, dataOe, ctrlOe, reqReady}, 0);
    // R10: requests during grant are ignored
    reqValid = 1'b1; reqKind = 3'd1;
    @(negedge clk);
    reqValid = 1'b0;
    busReqN = 1'b1;
    @(negedge clk);
    chk(busAckN === 1'b1 && ctrlOe === 1'b1 && addrOe === 1'b1, "R10", "return from grant",
        {busAckN, ctrlOe, addrOe}, 3'b111);
    chk(mreqN === 1'b1 && reqReady === 1'b1, "R10", "request during grant ignored",
        {mreqN, reqReady}, 2'b11);

    // R10/R11: request while idle
    busReqN = 1'b0;
    #1;
    chk(reqReady === 1'b0, "R11", "ready drops with bus request", reqReady, 0);
    @(negedge clk);
    chk(busAckN === 1'b0 && ctrlOe === 1'b0, "R10", "idle grant", {busAckN, ctrlOe}, 0);
    busReqN = 1'b1;
    @(negedge clk);
    chk(busAckN === 1'b1, "R10", "idle release", busAckN, 1);

    // a final write after all the above
    doCycle(4, -1, 1, 1, 1'b0, 8'h00, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule